// File: doc/BRIEF.md
# Warp load address coalescer

The coalescer accepts one load request for a whole warp: a byte address for each of 32 lanes plus a mask of the lanes that take part. It groups the active lanes by the aligned 128-byte memory segment their address falls in and issues one memory transaction per distinct segment. A transaction carries the segment base address and the mask of lanes it serves, and leaves on a valid/ready port at most one per cycle.

A warp whose active lanes all sit inside one aligned segment costs a single transaction. A contiguous run of words that starts off a segment boundary costs one extra transaction, not one per lane. While a warp is being split, the request port is held not ready. A one-cycle done pulse marks the end of each request. A transaction counter shows how many transactions the current request has issued so far.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `req_ready_o` is 1, `txn_valid_o` is 0, `done_o` is 0 and `txn_count_o` is 0.
- R2: Every transaction base is the lane byte address with bits [6:0] cleared, and every lane in a transaction's lane mask has an address inside that 128-byte segment.
- R3: When all active lanes address one aligned segment, exactly one transaction is issued, and its lane mask equals the active mask.
- R4: Inactive lanes never appear in a lane mask, and their addresses do not change the transactions issued.
- R5: A request with an all-zero mask issues no transaction. `done_o` is 1 in the cycle after it is accepted, and `txn_count_o` stays 0.
- R6: Transaction k serves the lowest-numbered active lane not yet served, together with every other unserved active lane in the same segment. The lane masks are disjoint, and together they cover the active mask.
- R7: While `txn_valid_o` is 1 and `txn_ready_i` is 0, the transaction holds its base and lane mask in the next cycle. A new transaction can be taken on every cycle with `txn_ready_i` at 1.
- R8: `req_ready_o` is 0 whenever `txn_valid_o` is 1.
- R9: `done_o` is 1 for exactly the cycle after the last transaction of a request is accepted, and it is never 1 together with `txn_valid_o`.
- R10: After a request completes, `txn_count_o` equals the number of distinct segments among its active lanes. The counter restarts at 0 when the next request is accepted.
- R11: With 4-byte words, lane i addressing word n+i costs one transaction when n*4 is 128-byte aligned and two transactions otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Warp request present |
| req_ready_o | output | 1 | Coalescer idle, request accepted on valid |
| req_addr_i | input | 1024 | Lane byte addresses, lane i in bits [32i+31:32i] |
| req_mask_i | input | 32 | Active-lane mask, bit i for lane i |
| txn_valid_o | output | 1 | Transaction present |
| txn_ready_i | input | 1 | Memory side takes the transaction |
| txn_base_o | output | 32 | Segment base byte address |
| txn_lanes_o | output | 32 | Lanes served by this transaction |
| txn_count_o | output | 6 | Transactions issued for the current request |
| done_o | output | 1 | One-cycle pulse at request completion |

## Verification
The bench builds the block with its default parameters: 32 lanes, 32-bit addresses and 128-byte segments. These defaults allow a worst case of 32 distinct segments per warp. They also cover every word-offset case of a contiguous run, including the boundary between the aligned and misaligned starts. Random warps mix unit, wide and zero strides with scattered lanes and sparse masks, under random back-pressure on the transaction port.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } coal_state_e;
endpackage

// File: rtl/coal_lane_store.sv
module coal_lane_store #(
  parameter int LANES = 32,
  parameter int TAG_W = 25
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [LANES*TAG_W-1:0] tags_i,
  input  logic [LANES-1:0]       mask_i,
  input  logic [LANES-1:0]       clear_i,
  output logic [LANES*TAG_W-1:0] tags_o,
  output logic [LANES-1:0]       pending_o
);
  logic [LANES*TAG_W-1:0] tags_q;
  logic [LANES-1:0]       pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tags_q <= '0;
      pend_q <= '0;
    end else if (load_i) begin
      tags_q <= tags_i;
      pend_q <= mask_i;
    end else begin
      pend_q <= pend_q & ~clear_i;
    end
  end

  assign tags_o    = tags_q;
  assign pending_o = pend_q;

  // pending set only shrinks between loads
  p_pending_shrink_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (pending_o & ~$past(pending_o)) == '0);
endmodule

// File: rtl/coal_lead_pick.sv
module coal_lead_pick #(
  parameter int LANES = 32,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] pending_i,
  output logic [LANES-1:0] onehot_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic [LANES:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < LANES; i++) begin : g_chain
    assign onehot_o[i] = pending_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | pending_i[i];
  end

  assign any_o = seen[LANES];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < LANES; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/coal_seg_match.sv
module coal_seg_match #(
  parameter int LANES = 32,
  parameter int TAG_W = 25
) (
  input  logic [LANES*TAG_W-1:0] tags_i,
  input  logic [LANES-1:0]       pending_i,
  input  logic [TAG_W-1:0]       lead_tag_i,
  output logic [LANES-1:0]       hit_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_cmp
    assign hit_o[i] = pending_i[i] && (tags_i[i*TAG_W +: TAG_W] == lead_tag_i);
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES     = 32,
  parameter int ADDR_W    = 32,
  parameter int SEG_BYTES = 128,
  localparam int SEG_LSB  = $clog2(SEG_BYTES),
  localparam int TAG_W    = ADDR_W - SEG_LSB,
  localparam int IDX_W    = $clog2(LANES),
  localparam int CNT_W    = $clog2(LANES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [LANES*ADDR_W-1:0] req_addr_i,
  input  logic [LANES-1:0]        req_mask_i,
  output logic                    txn_valid_o,
  input  logic                    txn_ready_i,
  output logic [ADDR_W-1:0]       txn_base_o,
  output logic [LANES-1:0]        txn_lanes_o,
  output logic [CNT_W-1:0]        txn_count_o,
  output logic                    done_o
);
  coal_state_e            state_q, state_d;
  logic [CNT_W-1:0]       count_q;
  logic                   done_q;
  logic [LANES*TAG_W-1:0] tags_in, tags_st;
  logic [LANES-1:0]       pending, lead_oh, hits, clear;
  logic [IDX_W-1:0]       lead_idx;
  logic                   lead_any;
  logic [TAG_W-1:0]       lead_tag;
  logic [LANES*SEG_LSB-1:0] unused_low;
  logic                   accept, hs, last;

  for (genvar i = 0; i < LANES; i++) begin : g_tag
    assign tags_in[i*TAG_W +: TAG_W]       = req_addr_i[i*ADDR_W+SEG_LSB +: TAG_W];
    assign unused_low[i*SEG_LSB +: SEG_LSB] = req_addr_i[i*ADDR_W +: SEG_LSB];
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i & req_ready_o;
  assign txn_valid_o = (state_q == ST_BUSY) & lead_any;
  assign hs          = txn_valid_o & txn_ready_i;
  assign clear       = hs ? hits : '0;
  assign last        = hs && ((pending & ~hits) == '0);

  coal_lane_store #(.LANES(LANES), .TAG_W(TAG_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .tags_i   (tags_in),
    .mask_i   (req_mask_i),
    .clear_i  (clear),
    .tags_o   (tags_st),
    .pending_o(pending)
  );

  coal_lead_pick #(.LANES(LANES)) u_pick (
    .pending_i(pending),
    .onehot_o (lead_oh),
    .idx_o    (lead_idx),
    .any_o    (lead_any)
  );

  assign lead_tag = tags_st[lead_idx*TAG_W +: TAG_W];

  coal_seg_match #(.LANES(LANES), .TAG_W(TAG_W)) u_match (
    .tags_i    (tags_st),
    .pending_i (pending),
    .lead_tag_i(lead_tag),
    .hit_o     (hits)
  );

  assign txn_base_o  = {lead_tag, {SEG_LSB{1'b0}}};
  assign txn_lanes_o = hits;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept && (req_mask_i != '0)) state_d = ST_BUSY;
      ST_BUSY: if (last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      count_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (accept && (req_mask_i == '0)) || last;
      if (accept)  count_q <= '0;
      else if (hs) count_q <= count_q + 1'b1;
    end
  end

  assign txn_count_o = count_q;
  assign done_o      = done_q;

  p_no_accept_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> !req_ready_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && !txn_ready_i |=> txn_valid_o && $stable(txn_base_o) && $stable(txn_lanes_o));
  p_done_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !txn_valid_o);
  p_disjoint_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && txn_ready_i |=> (txn_lanes_o & $past(txn_lanes_o)) == '0);
  p_leader_served_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> $onehot0(lead_oh) && ((lead_oh & ~txn_lanes_o) == '0));
  p_count_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_count_o <= CNT_W'(LANES));
endmodule

// File: tb/warp_coalescer_test.sv
module warp_coalescer_test;
  localparam int LANES = 32;
  localparam int AW    = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [LANES*AW-1:0] req_addr = '0;
  logic [LANES-1:0]  req_mask = '0;
  logic              txn_valid;
  logic              txn_ready = 1'b0;
  logic [AW-1:0]     txn_base;
  logic [LANES-1:0]  txn_lanes;
  logic [5:0]        txn_count;
  logic              done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0]      a [LANES];
  logic [31:0]      exp_base  [LANES];
  logic [LANES-1:0] exp_lanes [LANES];
  int               nexp;

  always #4 clk = ~clk;

  warp_coalescer uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_mask_i(req_mask), .txn_valid_o(txn_valid),
    .txn_ready_i(txn_ready), .txn_base_o(txn_base), .txn_lanes_o(txn_lanes),
    .txn_count_o(txn_count), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void build_expected(input logic [LANES-1:0] m);
    logic [LANES-1:0] pend = m;
    nexp = 0;
    while (pend != '0) begin
      int lead = 0;
      logic [24:0] tag;
      for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lead = i;
      tag = a[lead][31:7];
      exp_base[nexp]  = {tag, 7'd0};
      exp_lanes[nexp] = '0;
      for (int i = 0; i < LANES; i++)
        if (pend[i] && a[i][31:7] == tag) exp_lanes[nexp][i] = 1'b1;
      pend = pend & ~exp_lanes[nexp];
      nexp++;
    end
  endfunction

  // drives one request and collects its transactions under back-pressure
  task automatic run_req(input logic [LANES-1:0] m, input int bp_pct, input string tag);
    int k = 0;
    int guard = 0;
    bit seen_done = 0;
    build_expected(m);
    @(negedge clk);
    chk(req_ready === 1'b1, {"R8 idle ready ", tag}, req_ready, 1);
    for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = a[i];
    req_mask  = m;
    req_valid = 1'b1;
    txn_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = $urandom;
    while (!seen_done && guard < 400) begin
      guard++;
      if (done) begin
        seen_done = 1;
        chk(txn_valid === 1'b0, {"R9 done quiet ", tag}, txn_valid, 0);
      end else if (txn_valid) begin
        chk(req_ready === 1'b0, {"R8 busy not ready ", tag}, req_ready, 0);
        if (k < nexp) begin
          chk(txn_base === exp_base[k], {"R2 base ", tag}, txn_base, exp_base[k]);
          chk(txn_lanes === exp_lanes[k], {"R6 lanes ", tag}, txn_lanes, exp_lanes[k]);
          chk((txn_lanes & ~m) == '0, {"R4 inactive lanes ", tag}, txn_lanes, m);
        end else begin
          chk(0, {"R10 extra txn ", tag}, k, nexp);
        end
        txn_ready = (($urandom % 100) >= bp_pct);
        if (txn_ready) k++;
        @(negedge clk);
        txn_ready = 1'b0;
        continue;
      end
      if (!seen_done) @(negedge clk);
    end
    chk(seen_done, {"R9 done seen ", tag}, seen_done, 1);
    chk(k == nexp, {"R10 txn number ", tag}, k, nexp);
    chk(txn_count == 6'(nexp), {"R10 count ", tag}, txn_count, nexp);
    @(negedge clk);
    chk(done === 1'b0, {"R9 done single cycle ", tag}, done, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready", req_ready, 1);
    chk(txn_valid === 1'b0, "R1 txn_valid", txn_valid, 0);
    chk(done === 1'b0, "R1 done", done, 0);
    chk(txn_count === 6'd0, "R1 count", txn_count, 0);
    rst_n = 1'b1;

    // R11 aligned contiguous run: one transaction
    for (int i = 0; i < LANES; i++) a[i] = 32'h0000_4000 + 4 * i;
    run_req('1, 0, "R11 aligned");
    chk(nexp == 1, "R11 aligned single", nexp, 1);
    chk(txn_count == 6'd1, "R3 one txn", txn_count, 1);

    // R11 misaligned run by one word: two transactions
    for (int i = 0; i < LANES; i++) a[i] = 32'h0000_4004 + 4 * i;
    run_req('1, 30, "R11 misaligned");
    chk(txn_count == 6'd2, "R11 misaligned two", txn_count, 2);

    // R5 empty mask
    @(negedge clk);
    req_mask = '0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(done === 1'b1, "R5 empty done", done, 1);
    chk(txn_valid === 1'b0, "R5 empty no txn", txn_valid, 0);
    chk(txn_count === 6'd0, "R5 empty count", txn_count, 0);
    @(negedge clk);
    chk(done === 1'b0, "R5 done drops", done, 0);

    // R4 inactive lanes scattered far away, active lanes in one segment
    for (int i = 0; i < LANES; i++) a[i] = (i % 2 == 1) ? $urandom : 32'h0001_0080 + i;
    run_req(32'h5555_5555, 20, "R4 odd scatter");
    chk(txn_count == 6'd1, "R4 ignored addresses", txn_count, 1);

    // R3 all lanes same word
    for (int i = 0; i < LANES; i++) a[i] = 32'h0000_0ffc;
    run_req(32'h8000_0001, 50, "R3 broadcast");

    // R6 worst case: every lane its own segment, reversed order
    for (int i = 0; i < LANES; i++) a[i] = 32'h0010_0000 + 128 * (LANES - 1 - i);
    run_req('1, 40, "R6 all distinct");
    chk(txn_count == 6'd32, "R10 thirty two", txn_count, 32);

    // R7 full throughput, random mixes
    for (int t = 0; t < 300; t++) begin
      int mode = $urandom % 4;
      logic [31:0] base = $urandom;
      int stride = (mode == 0) ? 4 : (mode == 1) ? 16 : (mode == 2) ? 0 : 64;
      for (int i = 0; i < LANES; i++) begin
        a[i] = base + stride * i;
        if (($urandom % 8) == 0) a[i] = base + ($urandom % 1024);
      end
      run_req(($urandom % 4 == 0) ? $urandom & $urandom : $urandom | 32'h1,
              (t % 3 == 0) ? 0 : 35, "R7 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule